// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Burst Address Counters

This block is a true two-port synchronous memory. Each side has its own clock, address input, write-data input, read-data output, write strobe, output enable and a pair of select inputs of opposite polarity. Either side can reach any word at any time. Both sides may reach the same word in the same cycle.

Each side holds the address it uses in an internal register that works as a burst counter. A load strobe takes the external address. A count enable steps the held address up by one and wraps at the top of the array. A clear input forces it to zero. A burst is therefore started with a single address and continued with count pulses only.

A per-side mode input sets the read latency. In flow-through mode, read data and its valid flag appear one clock edge after the access edge. In pipelined mode they appear two edges after it. The read stream is valid-only: the outputs cannot be stalled and there is no ready input. A consumer that is not able to take a word when `*_dout_vld` is high loses that word. Address width `AW` (15 to 17 in full-size use, 8 by default here) and data width `DW` (8 or 9) are parameters.

Top module: `dpr_burst_ram`

## Requirements
- R1: The two sides work independently, each on its own clock edges, and random mixed traffic on both sides returns the last written data at every read.
- R2: With `*_pipe` low, a read accessed at edge k shows `*_dout_vld` high and its data on `*_dout` after edge k, before edge k+1.
- R3: With `*_pipe` high, a read accessed at edge k shows `*_dout_vld` high and its data after edge k+1.
- R4: At each edge the access address is chosen in this order. Clear gives zero. Otherwise load gives the external address. Otherwise count gives the held address plus one. Otherwise the held address is kept. The chosen address is used for this edge's access and is held afterwards.
- R5: Counting up from address 2^AW-1 gives address 0. A burst continues across this wrap in both read modes.
- R6: A side is selected only when `*_cs_n` is low and `*_cs` is high. A deselected side writes nothing and shows `*_dout_vld` low for the matching output cycle. Its first output register keeps its last word.
- R7: `*_wr` high on a selected side writes `*_din` at the access address. `*_wr` low on a selected side is a read.
- R8: `*_dout_drv` is high exactly when `*_dout_vld` and `*_oe` are both high.
- R9: When both sides write the same address at the same edge, side A's data is stored.
- R10: A read on one side at the same edge as a write to that address on the other side returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, for counters and output registers |
| a_clk | input | 1 | Side A clock |
| a_addr | input | AW | Side A external address |
| a_din | input | DW | Side A write data |
| a_dout | output | DW | Side A read data |
| a_dout_vld | output | 1 | Side A read data valid |
| a_dout_drv | output | 1 | Side A read data drive enable (valid and oe) |
| a_wr | input | 1 | Side A write strobe (1 write, 0 read) |
| a_oe | input | 1 | Side A output enable, active high |
| a_cs_n | input | 1 | Side A select, active low |
| a_cs | input | 1 | Side A select, active high |
| a_ld | input | 1 | Side A load external address |
| a_inc | input | 1 | Side A count enable |
| a_clr | input | 1 | Side A counter clear |
| a_pipe | input | 1 | Side A read mode (1 pipelined, 0 flow-through) |
| b_clk | input | 1 | Side B clock |
| b_addr | input | AW | Side B external address |
| b_din | input | DW | Side B write data |
| b_dout | output | DW | Side B read data |
| b_dout_vld | output | 1 | Side B read data valid |
| b_dout_drv | output | 1 | Side B read data drive enable |
| b_wr | input | 1 | Side B write strobe |
| b_oe | input | 1 | Side B output enable |
| b_cs_n | input | 1 | Side B select, active low |
| b_cs | input | 1 | Side B select, active high |
| b_ld | input | 1 | Side B load external address |
| b_inc | input | 1 | Side B count enable |
| b_clr | input | 1 | Side B counter clear |
| b_pipe | input | 1 | Side B read mode |

## Verification
The bench walks bursts through address 2^AW-1 into 0 in both read modes. A counter that saturated or skipped a word there would return data from the wrong address. It drives clear, load and count at the same time to expose a wrong priority order, which would show up as a burst starting at the external address instead of zero. It writes the same word from both sides at once, and reads a word on one side while the other side rewrites it. A wrong winner or a read of the new data would show as a data mismatch. It also switches only one of the two select inputs, where a selection decoded from a single input would leave a stray write behind.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_INC  = 2'd1,
    CTR_LOAD = 2'd2,
    CTR_ZERO = 2'd3
  } ctr_op_e;

  // Fixed priority among the counter controls.
  function automatic ctr_op_e pick_ctr_op(input logic clr, input logic ld, input logic inc);
    ctr_op_e op;
    if (clr)      op = CTR_ZERO;
    else if (ld)  op = CTR_LOAD;
    else if (inc) op = CTR_INC;
    else          op = CTR_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr
  import dpr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr
);

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  ctr_op_e       op;
  logic [AW-1:0] held_addr;

  always_comb begin
    op = pick_ctr_op(clr, ld, inc);
    unique case (op)
      CTR_ZERO: acc_addr = '0;
      CTR_LOAD: acc_addr = ext_addr;
      CTR_INC:  acc_addr = held_addr + 1'b1;
      default:  acc_addr = held_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_addr <= '0;
    else        held_addr <= acc_addr;
  end

  // R4
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> held_addr == '0);

  // R4
  load_over_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> held_addr == $past(ext_addr));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !inc) |=> $stable(held_addr));

  // R5
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !clr && held_addr == TOP_ADDR) |=> held_addr == '0);

endmodule

// File: rtl/dpr_read_pipe.sv
module dpr_read_pipe #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [DW-1:0] rd_word,
  input  logic          pipe_mode,
  input  logic          oe,
  output logic [DW-1:0] q,
  output logic          q_vld,
  output logic          q_drv
);

  logic [DW-1:0] st1_q, st2_q;
  logic          st1_v, st2_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st1_v <= 1'b0;
      st2_q <= '0;
      st2_v <= 1'b0;
    end else begin
      st1_v <= rd_fire;
      if (rd_fire) st1_q <= rd_word;
      st2_v <= st1_v;
      st2_q <= st1_q;
    end
  end

  assign q     = pipe_mode ? st2_q : st1_q;
  assign q_vld = pipe_mode ? st2_v : st1_v;
  assign q_drv = q_vld & oe;

  // R2
  flow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire ##1 !pipe_mode) |-> q_vld);

  // R3
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire ##2 pipe_mode) |-> q_vld);

  // R6
  idle_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(st1_q));

  // R6
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire ##1 !pipe_mode) |-> !q_vld);

endmodule

// File: rtl/dpr_xor_bank.sv
module dpr_xor_bank #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata0 = cells[raddr0];
  assign rdata1 = cells[raddr1];

endmodule

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          wr,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          ld,
  input  logic          inc,
  input  logic          clr,
  input  logic          pipe_mode,
  input  logic          oe,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] acc_addr,
  output logic          wr_fire,
  output logic [DW-1:0] q,
  output logic          q_vld,
  output logic          q_drv
);

  logic sel_ok;
  logic rd_fire;

  assign sel_ok  = !cs_n && cs;
  assign rd_fire = sel_ok && !wr;
  assign wr_fire = sel_ok && wr;

  dpr_addr_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .ld       (ld),
    .inc      (inc),
    .ext_addr (ext_addr),
    .acc_addr (acc_addr)
  );

  dpr_read_pipe #(.DW(DW)) u_rpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_word   (rd_word),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .q         (q),
    .q_vld     (q_vld),
    .q_drv     (q_drv)
  );

  // R6
  half_select_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n || !cs) ##1 !pipe_mode) |-> !q_vld);

endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram
  import dpr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          rst_n,
  input  logic          a_clk,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_dout_vld,
  output logic          a_dout_drv,
  input  logic          a_wr,
  input  logic          a_oe,
  input  logic          a_cs_n,
  input  logic          a_cs,
  input  logic          a_ld,
  input  logic          a_inc,
  input  logic          a_clr,
  input  logic          a_pipe,
  input  logic          b_clk,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          b_dout_vld,
  output logic          b_dout_drv,
  input  logic          b_wr,
  input  logic          b_oe,
  input  logic          b_cs_n,
  input  logic          b_cs,
  input  logic          b_ld,
  input  logic          b_inc,
  input  logic          b_clr,
  input  logic          b_pipe
);

  localparam int NSIDE = 2;

  logic          clk_v   [NSIDE];
  logic [AW-1:0] addr_v  [NSIDE];
  logic [DW-1:0] din_v   [NSIDE];
  logic          wr_v    [NSIDE];
  logic          oe_v    [NSIDE];
  logic          csn_v   [NSIDE];
  logic          cs_v    [NSIDE];
  logic          ld_v    [NSIDE];
  logic          inc_v   [NSIDE];
  logic          clr_v   [NSIDE];
  logic          pipe_v  [NSIDE];

  logic [AW-1:0] acc     [NSIDE];
  logic          wr_fire [NSIDE];
  logic          bank_we [NSIDE];
  logic [DW-1:0] rd_word [NSIDE];
  logic [DW-1:0] q_v     [NSIDE];
  logic          vld_v   [NSIDE];
  logic          drv_v   [NSIDE];
  // bank_rd[g][p]: bank g read at side p's access address
  logic [DW-1:0] bank_rd [NSIDE][NSIDE];

  assign clk_v[0]  = a_clk;   assign clk_v[1]  = b_clk;
  assign addr_v[0] = a_addr;  assign addr_v[1] = b_addr;
  assign din_v[0]  = a_din;   assign din_v[1]  = b_din;
  assign wr_v[0]   = a_wr;    assign wr_v[1]   = b_wr;
  assign oe_v[0]   = a_oe;    assign oe_v[1]   = b_oe;
  assign csn_v[0]  = a_cs_n;  assign csn_v[1]  = b_cs_n;
  assign cs_v[0]   = a_cs;    assign cs_v[1]   = b_cs;
  assign ld_v[0]   = a_ld;    assign ld_v[1]   = b_ld;
  assign inc_v[0]  = a_inc;   assign inc_v[1]  = b_inc;
  assign clr_v[0]  = a_clr;   assign clr_v[1]  = b_clr;
  assign pipe_v[0] = a_pipe;  assign pipe_v[1] = b_pipe;

  // Side A has priority on a same-address double write.
  assign bank_we[0] = wr_fire[0];
  assign bank_we[1] = wr_fire[1] && !(wr_fire[0] && (acc[0] == acc[1]));

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dpr_port #(.AW(AW), .DW(DW)) u_port (
      .clk       (clk_v[g]),
      .rst_n     (rst_n),
      .ext_addr  (addr_v[g]),
      .wr        (wr_v[g]),
      .cs_n      (csn_v[g]),
      .cs        (cs_v[g]),
      .ld        (ld_v[g]),
      .inc       (inc_v[g]),
      .clr       (clr_v[g]),
      .pipe_mode (pipe_v[g]),
      .oe        (oe_v[g]),
      .rd_word   (rd_word[g]),
      .acc_addr  (acc[g]),
      .wr_fire   (wr_fire[g]),
      .q         (q_v[g]),
      .q_vld     (vld_v[g]),
      .q_drv     (drv_v[g])
    );

    // Each bank is written by one side only; a word is the XOR of both banks.
    dpr_xor_bank #(.AW(AW), .DW(DW)) u_bank (
      .wclk   (clk_v[g]),
      .we     (bank_we[g]),
      .waddr  (acc[g]),
      .wdata  (din_v[g] ^ bank_rd[NSIDE-1-g][g]),
      .raddr0 (acc[0]),
      .raddr1 (acc[1]),
      .rdata0 (bank_rd[g][0]),
      .rdata1 (bank_rd[g][1])
    );

    assign rd_word[g] = bank_rd[0][g] ^ bank_rd[1][g];
  end

  assign a_dout     = q_v[0];
  assign a_dout_vld = vld_v[0];
  assign a_dout_drv = drv_v[0];
  assign b_dout     = q_v[1];
  assign b_dout_vld = vld_v[1];
  assign b_dout_drv = drv_v[1];

  // R9
  a_wins_collision_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (wr_fire[0] && wr_fire[1] && acc[0] == acc[1]) |-> !bank_we[1]);

  // R6
  deselect_no_write_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_cs_n || !a_cs) |-> !bank_we[0]);

endmodule

// File: tb/dpr_burst_ram_test.sv
module dpr_burst_ram_test;

  localparam int AW    = 8;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;

  // applied (i_) and staged (n_) inputs per side
  logic [AW-1:0] i_addr [2], n_addr [2];
  logic [DW-1:0] i_din  [2], n_din  [2];
  logic i_wr [2], n_wr [2], i_oe [2], n_oe [2];
  logic i_csn[2], n_csn[2], i_cs [2], n_cs [2];
  logic i_ld [2], n_ld [2], i_inc[2], n_inc[2];
  logic i_clr[2], n_clr[2], i_pipe[2], n_pipe[2];

  logic [DW-1:0] a_dout, b_dout;
  logic a_dout_vld, a_dout_drv, b_dout_vld, b_dout_drv;

  // reference model state
  logic [DW-1:0] m_mem [DEPTH];
  int            m_cnt [2];
  logic [DW-1:0] m_s1d [2], m_s2d [2];
  logic          m_s1v [2], m_s2v [2];

  dpr_burst_ram #(.AW(AW), .DW(DW)) uut (
    .rst_n(rst_n),
    .a_clk(clk), .a_addr(i_addr[0]), .a_din(i_din[0]), .a_dout(a_dout),
    .a_dout_vld(a_dout_vld), .a_dout_drv(a_dout_drv), .a_wr(i_wr[0]), .a_oe(i_oe[0]),
    .a_cs_n(i_csn[0]), .a_cs(i_cs[0]), .a_ld(i_ld[0]), .a_inc(i_inc[0]),
    .a_clr(i_clr[0]), .a_pipe(i_pipe[0]),
    .b_clk(clk), .b_addr(i_addr[1]), .b_din(i_din[1]), .b_dout(b_dout),
    .b_dout_vld(b_dout_vld), .b_dout_drv(b_dout_drv), .b_wr(i_wr[1]), .b_oe(i_oe[1]),
    .b_cs_n(i_csn[1]), .b_cs(i_cs[1]), .b_ld(i_ld[1]), .b_inc(i_inc[1]),
    .b_clr(i_clr[1]), .b_pipe(i_pipe[1])
  );

  function automatic logic [DW-1:0] pat(input int k);
    return DW'((k * 37 + 5) % (1 << DW));
  endfunction

  task automatic check_side(input int p, input string tag);
    logic [DW-1:0] got_q;
    logic got_v, got_d, exp_v, exp_d;
    logic [DW-1:0] exp_q;
    got_q = (p == 0) ? a_dout : b_dout;
    got_v = (p == 0) ? a_dout_vld : b_dout_vld;
    got_d = (p == 0) ? a_dout_drv : b_dout_drv;
    exp_v = i_pipe[p] ? m_s2v[p] : m_s1v[p];
    exp_q = i_pipe[p] ? m_s2d[p] : m_s1d[p];
    exp_d = exp_v && i_oe[p];
    n_checks++;
    if (got_v !== exp_v) begin
      n_fails++;
      $display("FAIL %s side%0d valid: got %0b expected %0b", tag, p, got_v, exp_v);
    end
    n_checks++;
    if (got_d !== exp_d) begin
      n_fails++;
      $display("FAIL %s side%0d drive: got %0b expected %0b", tag, p, got_d, exp_d);
    end
    if (exp_v) begin
      n_checks++;
      if (got_q !== exp_q) begin
        n_fails++;
        $display("FAIL %s side%0d data: got %0h expected %0h", tag, p, got_q, exp_q);
      end
    end
  endtask

  task automatic model_step();
    int eff [2];
    logic sel [2];
    logic [DW-1:0] rv [2];
    for (int p = 0; p < 2; p++) begin
      sel[p] = !i_csn[p] && i_cs[p];
      if (i_clr[p])      eff[p] = 0;
      else if (i_ld[p])  eff[p] = int'(i_addr[p]);
      else if (i_inc[p]) eff[p] = (m_cnt[p] + 1) % DEPTH;
      else               eff[p] = m_cnt[p];
      rv[p] = m_mem[eff[p]];
    end
    if (sel[1] && i_wr[1] && !(sel[0] && i_wr[0] && eff[0] == eff[1]))
      m_mem[eff[1]] = i_din[1];
    if (sel[0] && i_wr[0]) m_mem[eff[0]] = i_din[0];
    for (int p = 0; p < 2; p++) begin
      m_s2d[p] = m_s1d[p];
      m_s2v[p] = m_s1v[p];
      m_s1v[p] = sel[p] && !i_wr[p];
      if (m_s1v[p]) m_s1d[p] = rv[p];
      m_cnt[p] = eff[p];
    end
  endtask

  task automatic tick(input string tag);
    check_side(0, tag);
    check_side(1, tag);
    for (int p = 0; p < 2; p++) begin
      i_addr[p] = n_addr[p]; i_din[p] = n_din[p]; i_wr[p] = n_wr[p];
      i_oe[p] = n_oe[p]; i_csn[p] = n_csn[p]; i_cs[p] = n_cs[p];
      i_ld[p] = n_ld[p]; i_inc[p] = n_inc[p]; i_clr[p] = n_clr[p];
      i_pipe[p] = n_pipe[p];
    end
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int p);
    n_addr[p] = '0; n_din[p] = '0; n_wr[p] = 1'b0; n_oe[p] = 1'b1;
    n_csn[p] = 1'b1; n_cs[p] = 1'b0; n_ld[p] = 1'b0; n_inc[p] = 1'b0;
    n_clr[p] = 1'b0;
  endtask

  task automatic acc(input int p, input logic wr, input logic ld, input logic inc,
                     input logic clr, input int addr, input logic [DW-1:0] din);
    n_csn[p] = 1'b0; n_cs[p] = 1'b1; n_wr[p] = wr; n_ld[p] = ld; n_inc[p] = inc;
    n_clr[p] = clr; n_addr[p] = AW'(addr); n_din[p] = din; n_oe[p] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p); n_pipe[p] = 1'b0;
      i_addr[p] = '0; i_din[p] = '0; i_wr[p] = 1'b0; i_oe[p] = 1'b1;
      i_csn[p] = 1'b1; i_cs[p] = 1'b0; i_ld[p] = 1'b0; i_inc[p] = 1'b0;
      i_clr[p] = 1'b0; i_pipe[p] = 1'b0;
      m_cnt[p] = 0; m_s1d[p] = '0; m_s2d[p] = '0; m_s1v[p] = 1'b0; m_s2v[p] = 1'b0;
    end
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: reset state, nothing valid or driven
    tick("R6");

    // R7: fill the whole array with one load and a counted burst on side A
    for (int k = 0; k < DEPTH; k++) begin
      acc(0, 1'b1, k == 0, k != 0, 1'b0, 0, pat(k));
      tick("R7");
    end
    idle(0);
    tick("R7");

    // R5 / R2: flow-through read burst on A across the top address
    for (int k = 0; k < 12; k++) begin
      acc(0, 1'b0, k == 0, k != 0, 1'b0, 250, '0);
      tick("R5");
    end
    idle(0);
    tick("R2");
    tick("R2");

    // R3 / R5: pipelined read burst on B across the wrap
    n_pipe[1] = 1'b1;
    tick("R3");
    for (int k = 0; k < 10; k++) begin
      acc(1, 1'b0, k == 0, k != 0, 1'b0, 252, '0);
      tick("R3");
    end
    idle(1);
    repeat (3) tick("R3");
    n_pipe[1] = 1'b0;
    tick("R3");

    // R4: control priority on B, flow-through reads
    acc(1, 1'b0, 1'b1, 1'b1, 1'b1, 77, '0); tick("R4");  // clear wins -> 0
    acc(1, 1'b0, 1'b1, 1'b1, 1'b0, 77, '0); tick("R4");  // load wins -> 77
    acc(1, 1'b0, 1'b0, 1'b1, 1'b0, 12, '0); tick("R4");  // count -> 78
    acc(1, 1'b0, 1'b0, 1'b0, 1'b0, 12, '0); tick("R4");  // hold -> 78
    idle(1);
    tick("R4");
    tick("R4");

    // R6: half selections must not write
    acc(0, 1'b1, 1'b1, 1'b0, 1'b0, 5, 9'h1AA); n_csn[0] = 1'b1; tick("R6");
    acc(0, 1'b1, 1'b1, 1'b0, 1'b0, 5, 9'h155); n_cs[0] = 1'b0; tick("R6");
    idle(0);
    acc(1, 1'b0, 1'b1, 1'b0, 1'b0, 5, '0); tick("R6");
    idle(1);
    tick("R6");
    tick("R6");

    // R8: output enable gating while reads stream
    for (int k = 0; k < 8; k++) begin
      acc(0, 1'b0, 1'b1, 1'b0, 1'b0, 10 + k, '0);
      n_oe[0] = k[0];
      tick("R8");
    end
    idle(0); n_oe[0] = 1'b0;
    tick("R8");
    tick("R8");

    // R9: both sides write one address at the same edge
    acc(0, 1'b1, 1'b1, 1'b0, 1'b0, 33, 9'h0F0);
    acc(1, 1'b1, 1'b1, 1'b0, 1'b0, 33, 9'h10F);
    tick("R9");
    acc(0, 1'b0, 1'b1, 1'b0, 1'b0, 33, '0);
    acc(1, 1'b0, 1'b1, 1'b0, 1'b0, 33, '0);
    tick("R9");
    idle(0); idle(1);
    tick("R9");
    tick("R9");

    // R10: read on B while A rewrites the same word, then read again
    acc(0, 1'b1, 1'b1, 1'b0, 1'b0, 40, 9'h0C3);
    acc(1, 1'b0, 1'b1, 1'b0, 1'b0, 40, '0);
    tick("R10");
    idle(0);
    acc(1, 1'b0, 1'b1, 1'b0, 1'b0, 40, '0);
    tick("R10");
    idle(1);
    tick("R10");
    tick("R10");

    // R1: random traffic on both sides
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < 2; p++) begin
        int r;
        r = int'($urandom % 8);
        n_addr[p] = (r < 4) ? AW'(r) : (r < 6) ? AW'(DEPTH - 7 + r) : AW'($urandom);
        n_din[p]  = DW'($urandom);
        n_wr[p]   = $urandom % 2 == 0;
        n_oe[p]   = $urandom % 5 != 0;
        n_csn[p]  = $urandom % 10 == 0;
        n_cs[p]   = $urandom % 10 != 0;
        n_ld[p]   = $urandom % 3 == 0;
        n_inc[p]  = $urandom % 2 == 0;
        n_clr[p]  = $urandom % 20 == 0;
        if ($urandom % 20 == 0) n_pipe[p] = ~n_pipe[p];
      end
      tick("R1");
    end
    idle(0); idle(1);
    repeat (4) tick("R1");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule